// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the software-facing side of a FIFO-based I2C master. It decodes 32-bit word accesses inside a 128-byte window. It holds the control, timing, interrupt, status, reset and bus-reset registers. It also owns two queues. The transmit queue carries both address commands and data bytes. The receive queue collects bytes from the bus engine and is drained through the same address that the transmit queue is filled through.

A separate bus engine generates the SCL/SDA waveforms. This block gives that engine the head of the transmit queue, a pop strobe, a push port into the receive queue, the control levels and pulses, and the timing values. The engine reports four kinds of events: receive byte count reached, no acknowledge, lost arbitration, and the last transmit entry consumed. These events set sticky interrupt status bits. Each status bit is gated by an enable mask, and the gated bits are combined onto one interrupt line.

Software clears status by writing ones to a separate clear register. It changes the bus timing only while the normal-operation bit is off. The noise filter and bus monitor registers are plain storage.

Top module: `i2cm_regs`

## Requirements
- R1: After reset, every storage register reads 0, the status register reads 0x0000_0003 (transmit queue empty and not full), `irq_o` is low and `tx_empty_o` is high.
- R2: Word offsets are decoded from `addr_i[6:2]`. The plain registers read back what was written, masked to their widths:
  - slave address at 0x0C, 7 bits;
  - timing at 0x10, 0x14, 0x18 and 0x1C, 16 bits each;
  - interrupt enable at 0x24;
  - bus monitor at 0x38, 8 bits;
  - noise filter at 0x3C, 8 bits;
  - transmit count at 0x40 and receive count at 0x44, 16 bits each.
  Offsets 0x08 and 0x30 read 0 and ignore writes.
- R3: A write to 0x04 pushes `wdata_i[8:0]` into the transmit queue. Bit 8 marks an address command, bits 7:1 carry the slave address and bit 0 is the read flag. The engine sees the entries on `tx_data_o` in order and removes them with `tx_pop_i`.
- R4: A read of 0x04 returns the oldest received byte in bits 7:0 and removes it. A read of 0x04 while the receive queue is empty returns 0 and changes nothing.
- R5: Each queue holds 8 entries, and a push into a full queue is dropped. The status register at 0x2C reports:
  - bit 12: device busy;
  - bit 8: bus busy;
  - bit 3: receive queue full;
  - bit 2: receive queue not empty;
  - bit 1: transmit queue not full;
  - bit 0: transmit queue empty.
- R6: In the control register at 0x00, bit 3 drives `master_o` and bit 0 drives `nack_o`. A write with bit 2 set gives a one-cycle pulse on `start_o`, and a write with bit 1 set gives a one-cycle pulse on `stop_o`. Bits 2 and 1 read back as 0.
- R7: The interrupt status register at 0x20 has four bits:
  - bit 9: set when the engine pops the last transmit entry;
  - bit 4: set by `rb_ev_i`;
  - bit 2: set by `nack_ev_i`;
  - bit 1: set by `al_ev_i`.
  Each bit stays set until it is cleared.
- R8: Writing a 1 to a bit of the clear register at 0x28 clears that status bit. Writing a 0 to a bit leaves it as it is. A set event in the same cycle as a clear wins.
- R9: `irq_o` is high exactly when some interrupt status bit and its enable bit at 0x24 are both 1.
- R10: The reset register at 0x34 acts through one-cycle pulses:
  - bit 2 empties the transmit queue;
  - bit 1 empties the receive queue;
  - bit 0 pulses `bus_rst_o` for one cycle.
  The register reads as 0.
- R11: At 0x50, bit 1 drives `run_o` (normal operation) and bit 0 drives `scl_free_o` (release a stuck-low clock). Writes to the timing registers are ignored while bit 1 is set.
- R12: Offsets 0x48 and 0x4C read the engine's transmit and receive count monitors, `tx_mon_i` and `rx_mon_i`. The busy inputs appear in status bits 12 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 7 | Byte address in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Combined interrupt |
| master_o | output | 1 | Master mode level |
| start_o | output | 1 | Start request pulse |
| stop_o | output | 1 | Stop request pulse |
| nack_o | output | 1 | Answer the next byte with NACK |
| slave_addr_o | output | 7 | Slave address register |
| cyc_o | output | 16 | Clock cycle count |
| low_o | output | 16 | Low-period count |
| rs_setup_o | output | 16 | Restart/stop setup count |
| dat_setup_o | output | 16 | Data setup count |
| noise_o | output | 8 | Noise filter setting |
| tx_bytes_o | output | 16 | Transmit byte count setting |
| rx_bytes_o | output | 16 | Receive byte count setting |
| bus_rst_o | output | 1 | Forced bus reset pulse |
| run_o | output | 1 | Normal operation enable |
| scl_free_o | output | 1 | Release stuck-low SCL |
| tx_pop_i | input | 1 | Engine removes the transmit head |
| tx_data_o | output | 9 | Transmit head entry |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_push_i | input | 1 | Engine stores a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive queue full |
| rb_ev_i | input | 1 | Receive count reached event |
| nack_ev_i | input | 1 | No acknowledge event |
| al_ev_i | input | 1 | Arbitration lost event |
| dev_busy_i | input | 1 | Device busy |
| bus_busy_i | input | 1 | Bus busy |
| tx_mon_i | input | 16 | Transmit count monitor |
| rx_mon_i | input | 16 | Receive count monitor |

## Verification
The hardest case to reach from the ports is a collision between an interrupt event and a clear of the same status bit in one cycle. The bench brings it about by raising `al_ev_i` on the same clock edge that commits a write to the clear register, and then reading the status back. The dropped ninth push can only be seen once the queue has been drained entry by entry, so the bench fills the transmit queue past its depth and pops it empty while checking each head value. It also fills the receive queue past its depth and then flushes it. The timing lock is probed by writing a timing register while normal operation is on, and comparing the readback with the value written before the lock was set.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int unsigned DW = 32;

  // word indices (byte offset / 4)
  localparam logic [4:0] A_CTRL  = 5'h00;
  localparam logic [4:0] A_FIFO  = 5'h01;
  localparam logic [4:0] A_SLAD  = 5'h03;
  localparam logic [4:0] A_TIM0  = 5'h04;
  localparam logic [4:0] A_ISTS  = 5'h08;
  localparam logic [4:0] A_IEN   = 5'h09;
  localparam logic [4:0] A_ICLR  = 5'h0A;
  localparam logic [4:0] A_STAT  = 5'h0B;
  localparam logic [4:0] A_RST   = 5'h0D;
  localparam logic [4:0] A_BMON  = 5'h0E;
  localparam logic [4:0] A_NF    = 5'h0F;
  localparam logic [4:0] A_TXB   = 5'h10;
  localparam logic [4:0] A_RXB   = 5'h11;
  localparam logic [4:0] A_TXM   = 5'h12;
  localparam logic [4:0] A_RXM   = 5'h13;
  localparam logic [4:0] A_BRST  = 5'h14;

  localparam int unsigned NTIM = 4;

  localparam int unsigned B_TE = 9;
  localparam int unsigned B_RB = 4;
  localparam int unsigned B_NA = 2;
  localparam int unsigned B_AL = 1;
  localparam logic [DW-1:0] IRQ_MASK = (32'd1 << B_TE) | (32'd1 << B_RB) |
                                       (32'd1 << B_NA) | (32'd1 << B_AL);
endpackage

// File: rtl/i2cm_fifo.sv
`timescale 1ns/1ps
module i2cm_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic [W-1:0]                 wdata_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 rdata_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = empty_o ? '0 : mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wr_q)); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R10
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !flush_i |=> empty_o && $stable(rd_q)); // R4
endmodule

// File: rtl/i2cm_irq.sv
`timescale 1ns/1ps
module i2cm_irq #(
  parameter int unsigned    DW   = 32,
  parameter logic [DW-1:0]  MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [DW-1:0] en_wdata_i,
  output logic [DW-1:0] sts_o,
  output logic [DW-1:0] en_o,
  output logic          irq_o
);
  logic [DW-1:0] sts_q, en_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_i) | set_i) & MASK;
      if (en_we_i) en_q <= en_wdata_i & MASK;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(sts_q) & ~$past(clr_i) & ~sts_q) == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & MASK) |=> ((sts_q & $past(set_i & MASK)) == $past(set_i & MASK))); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o); // R9
endmodule

// File: rtl/i2cm_regs.sv
`timescale 1ns/1ps
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int unsigned AW     = 7,
  parameter int unsigned TIM_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NF_W   = 8,
  parameter int unsigned BM_W   = 8,
  parameter int unsigned SA_W   = 7,
  parameter int unsigned TX_W   = 9,
  parameter int unsigned RX_W   = 8,
  parameter int unsigned DEPTH  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             master_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             nack_o,
  output logic [SA_W-1:0]  slave_addr_o,
  output logic [TIM_W-1:0] cyc_o,
  output logic [TIM_W-1:0] low_o,
  output logic [TIM_W-1:0] rs_setup_o,
  output logic [TIM_W-1:0] dat_setup_o,
  output logic [NF_W-1:0]  noise_o,
  output logic [CNT_W-1:0] tx_bytes_o,
  output logic [CNT_W-1:0] rx_bytes_o,
  output logic             bus_rst_o,
  output logic             run_o,
  output logic             scl_free_o,
  input  logic             tx_pop_i,
  output logic [TX_W-1:0]  tx_data_o,
  output logic             tx_empty_o,
  input  logic             rx_push_i,
  input  logic [RX_W-1:0]  rx_data_i,
  output logic             rx_full_o,
  input  logic             rb_ev_i,
  input  logic             nack_ev_i,
  input  logic             al_ev_i,
  input  logic             dev_busy_i,
  input  logic             bus_busy_i,
  input  logic [CNT_W-1:0] tx_mon_i,
  input  logic [CNT_W-1:0] rx_mon_i
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [4:0]       idx;
  logic             wr, rd;
  logic             mst_q, nack_q, start_q, stop_q, bus_rst_q, run_q, scl_q;
  logic [SA_W-1:0]  slad_q;
  logic [TIM_W-1:0] tim_q [NTIM];
  logic [NF_W-1:0]  nf_q;
  logic [BM_W-1:0]  bm_q;
  logic [CNT_W-1:0] txb_q, rxb_q;

  logic             tx_flush, rx_flush, tx_push, rx_pop;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, rx_empty;
  logic [RX_W-1:0]  rx_head;
  logic [DW-1:0]    irq_set, irq_clr, sts, ien, stat;

  assign idx = addr_i[6:2];
  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;

  assign tx_push  = wr && (idx == A_FIFO);
  assign rx_pop   = rd && (idx == A_FIFO);
  assign tx_flush = wr && (idx == A_RST) && wdata_i[2];
  assign rx_flush = wr && (idx == A_RST) && wdata_i[1];

  i2cm_fifo #(.W(TX_W), .DEPTH(DEPTH)) u_txq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (tx_push),
    .wdata_i (wdata_i[TX_W-1:0]),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_data_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty_o)
  );

  i2cm_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (rx_push_i),
    .wdata_i (rx_data_i),
    .pop_i   (rx_pop),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full_o),
    .empty_o (rx_empty)
  );

  // TE fires when the engine takes the final queued entry
  always_comb begin
    irq_set       = '0;
    irq_set[B_TE] = tx_pop_i && (tx_cnt == CW'(1)) && !tx_flush;
    irq_set[B_RB] = rb_ev_i;
    irq_set[B_NA] = nack_ev_i;
    irq_set[B_AL] = al_ev_i;
  end
  assign irq_clr = (wr && (idx == A_ICLR)) ? wdata_i : '0;

  i2cm_irq #(.DW(DW), .MASK(IRQ_MASK)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (irq_set),
    .clr_i      (irq_clr),
    .en_we_i    (wr && (idx == A_IEN)),
    .en_wdata_i (wdata_i),
    .sts_o      (sts),
    .en_o       (ien),
    .irq_o      (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q     <= 1'b0;
      nack_q    <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      bus_rst_q <= 1'b0;
      run_q     <= 1'b0;
      scl_q     <= 1'b0;
      slad_q    <= '0;
      nf_q      <= '0;
      bm_q      <= '0;
      txb_q     <= '0;
      rxb_q     <= '0;
    end else begin
      start_q   <= wr && (idx == A_CTRL) && wdata_i[2];
      stop_q    <= wr && (idx == A_CTRL) && wdata_i[1];
      bus_rst_q <= wr && (idx == A_RST) && wdata_i[0];
      if (wr) begin
        case (idx)
          A_CTRL: begin
            mst_q  <= wdata_i[3];
            nack_q <= wdata_i[0];
          end
          A_SLAD: slad_q <= wdata_i[SA_W-1:0];
          A_NF:   nf_q   <= wdata_i[NF_W-1:0];
          A_BMON: bm_q   <= wdata_i[BM_W-1:0];
          A_TXB:  txb_q  <= wdata_i[CNT_W-1:0];
          A_RXB:  rxb_q  <= wdata_i[CNT_W-1:0];
          A_BRST: begin
            run_q <= wdata_i[1];
            scl_q <= wdata_i[0];
          end
          default: ;
        endcase
      end
    end
  end

  // timing registers, locked while normal operation is on
  for (genvar i = 0; i < NTIM; i++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tim_q[i] <= '0;
      else if (wr && !run_q && (idx == A_TIM0 + 5'(i)))
        tim_q[i] <= wdata_i[TIM_W-1:0];
    end

    AST_TIM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_q |=> $stable(tim_q[i])); // R11
  end

  always_comb begin
    stat     = '0;
    stat[12] = dev_busy_i;
    stat[8]  = bus_busy_i;
    stat[3]  = rx_full_o;
    stat[2]  = !rx_empty;
    stat[1]  = !tx_full;
    stat[0]  = tx_empty_o;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (idx)
        A_CTRL:      rdata_o = DW'({mst_q, 2'b00, nack_q});
        A_FIFO:      rdata_o = DW'(rx_head);
        A_SLAD:      rdata_o = DW'(slad_q);
        A_TIM0:      rdata_o = DW'(tim_q[0]);
        A_TIM0 + 1:  rdata_o = DW'(tim_q[1]);
        A_TIM0 + 2:  rdata_o = DW'(tim_q[2]);
        A_TIM0 + 3:  rdata_o = DW'(tim_q[3]);
        A_ISTS:      rdata_o = sts;
        A_IEN:       rdata_o = ien;
        A_STAT:      rdata_o = stat;
        A_BMON:      rdata_o = DW'(bm_q);
        A_NF:        rdata_o = DW'(nf_q);
        A_TXB:       rdata_o = DW'(txb_q);
        A_RXB:       rdata_o = DW'(rxb_q);
        A_TXM:       rdata_o = DW'(tx_mon_i);
        A_RXM:       rdata_o = DW'(rx_mon_i);
        A_BRST:      rdata_o = DW'({run_q, scl_q});
        default:     rdata_o = '0;
      endcase
    end
  end

  assign master_o     = mst_q;
  assign nack_o       = nack_q;
  assign start_o      = start_q;
  assign stop_o       = stop_q;
  assign bus_rst_o    = bus_rst_q;
  assign run_o        = run_q;
  assign scl_free_o   = scl_q;
  assign slave_addr_o = slad_q;
  assign cyc_o        = tim_q[0];
  assign low_o        = tim_q[1];
  assign rs_setup_o   = tim_q[2];
  assign dat_setup_o  = tim_q[3];
  assign noise_o      = nf_q;
  assign tx_bytes_o   = txb_q;
  assign rx_bytes_o   = rxb_q;

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R6
  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o); // R6
  AST_BUS_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o |=> !bus_rst_o); // R10
  AST_RX_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop && rx_empty |-> rdata_o == '0); // R4
endmodule

// File: tb/tb_i2cm_regs.sv
`timescale 1ns/1ps
module tb_i2cm_regs;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0;
  logic [6:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o, master_o, start_o, stop_o, nack_o;
  logic [6:0]  slave_addr_o;
  logic [15:0] cyc_o, low_o, rs_setup_o, dat_setup_o, tx_bytes_o, rx_bytes_o;
  logic [7:0]  noise_o;
  logic        bus_rst_o, run_o, scl_free_o;
  logic        tx_pop_i = 0, tx_empty_o, rx_push_i = 0, rx_full_o;
  logic [8:0]  tx_data_o;
  logic [7:0]  rx_data_i = '0;
  logic        rb_ev_i = 0, nack_ev_i = 0, al_ev_i = 0, dev_busy_i = 0, bus_busy_i = 0;
  logic [15:0] tx_mon_i = '0, rx_mon_i = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2cm_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .master_o(master_o),
    .start_o(start_o), .stop_o(stop_o), .nack_o(nack_o), .slave_addr_o(slave_addr_o),
    .cyc_o(cyc_o), .low_o(low_o), .rs_setup_o(rs_setup_o), .dat_setup_o(dat_setup_o),
    .noise_o(noise_o), .tx_bytes_o(tx_bytes_o), .rx_bytes_o(rx_bytes_o),
    .bus_rst_o(bus_rst_o), .run_o(run_o), .scl_free_o(scl_free_o),
    .tx_pop_i(tx_pop_i), .tx_data_o(tx_data_o), .tx_empty_o(tx_empty_o),
    .rx_push_i(rx_push_i), .rx_data_i(rx_data_i), .rx_full_o(rx_full_o),
    .rb_ev_i(rb_ev_i), .nack_ev_i(nack_ev_i), .al_ev_i(al_ev_i),
    .dev_busy_i(dev_busy_i), .bus_busy_i(bus_busy_i),
    .tx_mon_i(tx_mon_i), .rx_mon_i(rx_mon_i)
  );

  // {addr, write data, expected readback}; 0x50 last since it locks timing
  localparam logic [71:0] VEC [14] = '{
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_007F},
    {8'h10, 32'h0001_2345, 32'h0000_2345},
    {8'h14, 32'hABCD_0010, 32'h0000_0010},
    {8'h18, 32'h0000_FFFF, 32'h0000_FFFF},
    {8'h1C, 32'h0000_0003, 32'h0000_0003},
    {8'h24, 32'hFFFF_FFFF, 32'h0000_0216},
    {8'h38, 32'h0000_01A5, 32'h0000_00A5},
    {8'h3C, 32'h0000_0007, 32'h0000_0007},
    {8'h40, 32'h0001_0005, 32'h0000_0005},
    {8'h44, 32'h0000_FFFF, 32'h0000_FFFF},
    {8'h08, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h30, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h34, 32'hFFFF_FFF8, 32'h0000_0000},
    {8'h50, 32'h0000_0003, 32'h0000_0003}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop_i = 1;
    @(negedge clk); tx_pop_i = 0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push_i = 1; rx_data_i = d;
    @(negedge clk); rx_push_i = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(7'h2C, d); check("R1 status", d, 32'h3);
    rd(7'h10, d); check("R1 timing", d, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 32'h0);
    check("R1 tx_empty", {31'd0, tx_empty_o}, 32'h1);

    // R2/R10/R11 table walk
    foreach (VEC[i]) begin
      wr(VEC[i][70:64], VEC[i][63:32]);
      rd(VEC[i][70:64], d);
      check($sformatf("R2 vec %0d", i), d, VEC[i][31:0]);
    end
    check("R11 run_o", {31'd0, run_o}, 32'h1);
    check("R11 scl_free_o", {31'd0, scl_free_o}, 32'h1);

    // R11 lock
    wr(7'h10, 32'h55); rd(7'h10, d); check("R11 locked", d, 32'h2345);
    wr(7'h50, 32'h0);  wr(7'h10, 32'h55); rd(7'h10, d); check("R11 unlocked", d, 32'h55);
    check("R11 cyc_o", {16'd0, cyc_o}, 32'h55);

    // R6 control
    wr(7'h00, 32'hF);
    check("R6 start pulse", {31'd0, start_o}, 32'h1);
    check("R6 stop pulse", {31'd0, stop_o}, 32'h1);
    @(negedge clk);
    check("R6 start end", {31'd0, start_o}, 32'h0);
    check("R6 master/nack", {30'd0, master_o, nack_o}, 32'h3);
    rd(7'h00, d); check("R6 readback", d, 32'h9);

    // R3 command + data, R7 TE, R8/R9
    wr(7'h04, 32'h1A1); wr(7'h04, 32'h03C);
    check("R3 head cmd", {23'd0, tx_data_o}, 32'h1A1);
    pop_tx();
    check("R3 head data", {23'd0, tx_data_o}, 32'h03C);
    check("R7 no TE yet", {31'd0, irq_o}, 32'h0);
    pop_tx();
    rd(7'h20, d); check("R7 TE set", d, 32'h200);
    check("R9 irq high", {31'd0, irq_o}, 32'h1);
    wr(7'h28, 32'h0); rd(7'h20, d); check("R8 zero no effect", d, 32'h200);
    wr(7'h28, 32'h200); rd(7'h20, d); check("R8 clear", d, 32'h0);
    check("R9 irq low", {31'd0, irq_o}, 32'h0);

    // R5 overfill TX
    for (int i = 0; i < 9; i++) wr(7'h04, 32'h10 + i);
    rd(7'h2C, d); check("R5 tx full status", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      check($sformatf("R5 tx order %0d", i), {23'd0, tx_data_o}, 32'h10 + i);
      pop_tx();
    end
    check("R5 ninth dropped", {31'd0, tx_empty_o}, 32'h1);
    wr(7'h28, 32'h216);

    // R4 RX
    push_rx(8'h11); push_rx(8'h22);
    rd(7'h2C, d); check("R5 rx not empty", d, 32'h7);
    rd(7'h04, d); check("R4 first", d, 32'h11);
    rd(7'h04, d); check("R4 second", d, 32'h22);
    rd(7'h04, d); check("R4 empty read", d, 32'h0);
    rd(7'h2C, d); check("R4 still empty", d, 32'h3);
    for (int i = 0; i < 9; i++) push_rx(8'(8'h40 + i));
    rd(7'h2C, d); check("R5 rx full", d, 32'hF);
    check("R5 rx_full_o", {31'd0, rx_full_o}, 32'h1);

    // R10 flushes and bus reset
    wr(7'h34, 32'h2); rd(7'h2C, d); check("R10 rx flush", d, 32'h3);
    wr(7'h04, 32'h1); wr(7'h04, 32'h2);
    check("R10 tx loaded", {31'd0, tx_empty_o}, 32'h0);
    wr(7'h34, 32'h4); check("R10 tx flush", {31'd0, tx_empty_o}, 32'h1);
    wr(7'h34, 32'h1); check("R10 bus reset pulse", {31'd0, bus_rst_o}, 32'h1);
    @(negedge clk); check("R10 pulse ends", {31'd0, bus_rst_o}, 32'h0);

    // R7 events, sticky
    @(negedge clk); rb_ev_i = 1; @(negedge clk); rb_ev_i = 0;
    nack_ev_i = 1; @(negedge clk); nack_ev_i = 0;
    al_ev_i = 1; @(negedge clk); al_ev_i = 0;
    rd(7'h20, d); check("R7 events", d, 32'h16);
    repeat (4) @(negedge clk);
    rd(7'h20, d); check("R7 sticky", d, 32'h16);
    wr(7'h28, 32'h4); rd(7'h20, d); check("R8 partial clear", d, 32'h12);

    // R8 set beats clear in same cycle
    @(negedge clk);
    al_ev_i = 1; req_i = 1; we_i = 1; addr_i = 7'h28; wdata_i = 32'h2;
    @(negedge clk);
    al_ev_i = 0; req_i = 0; we_i = 0;
    rd(7'h20, d); check("R8 set wins", d, 32'h12);
    wr(7'h24, 32'h0);
    check("R9 masked", {31'd0, irq_o}, 32'h0);
    wr(7'h28, 32'h12); rd(7'h20, d); check("R8 clear all", d, 32'h0);

    // R12 busy and monitors
    dev_busy_i = 1; bus_busy_i = 1; tx_mon_i = 16'h1234; rx_mon_i = 16'hBEEF;
    rd(7'h2C, d); check("R12 busy bits", d, 32'h1103);
    rd(7'h48, d); check("R12 tx monitor", d, 32'h1234);
    rd(7'h4C, d); check("R12 rx monitor", d, 32'hBEEF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule